// File: doc/BRIEF.md
# Byte-Register UART Host Front End

This block sits between a simple read/write register bus and the serial engine of a small UART. Software sees eight byte-wide registers placed on word boundaries: four read-only identification bytes, a data port, a combined status/control byte and the two halves of the baud divisor. Behind the data port sit a four-character receive queue and a one-character transmit holding slot.

The serial engine hands received characters over with a one-cycle valid strobe and reports framing problems with a separate one-cycle strobe. It collects outgoing characters through a valid/take handshake. Framing and overflow problems are kept as sticky flags until software clears them. Receive and transmit events share a single registered interrupt line. Each direction is gated by its own enable bit in the status byte.

Top module: `uart_regfront`

## Requirements
- R1: After reset the status byte reads 0xA0 (receive empty bit 5 and transmit empty bit 7 set, all else 0), the interrupt is low, tx_valid is low and baud_div is 0.
- R2: Reads at offsets 0, 4, 8 and 12 return the bytes of the ID_WORD parameter, least significant byte first; writes there have no effect.
- R3: Writes at offset 24 set bits 7:0 and writes at offset 28 set bits 15:8 of baud_div; both read back what was written.
- R4: The receive queue holds four characters. A read at offset 16 returns the oldest one and removes it, in arrival order.
- R5: The status byte shows queue level as bit 3 (four held), bit 4 (exactly three held, room for one) and bit 5 (none held).
- R6: A character arriving while four are held is dropped, and status bit 1 (overflow) becomes 1.
- R7: A frame-error strobe sets status bit 1's neighbour, bit 0, which stays set until software clears it.
- R8: A status write (offset 20) loads bit 2 (receive interrupt enable) and bit 6 (transmit interrupt enable). Bits 0 and 1 are cleared by writing 0 and are left unchanged by writing 1. Bits 3, 4, 5 and 7 ignore writes.
- R9: A data write while status bit 7 is 1 loads the transmit slot, raises tx_valid and clears bit 7 until tx_take is seen. A data write while the slot is occupied is ignored.
- R10: One cycle after the state changes, the interrupt equals (bit 2 AND (queue not empty OR bit 0 OR bit 1)) OR (bit 6 AND bit 7). An error alone, with the queue empty, is enough for a receive interrupt.
- R11: A data read with the receive queue empty returns 0x00 and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; low two bits must be zero |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Combined receive/transmit interrupt, registered |
| rx_valid | input | 1 | Received character strobe from the serial engine |
| rx_data | input | 8 | Received character |
| rx_frame_err | input | 1 | Frame error strobe from the serial engine |
| tx_valid | output | 1 | Transmit slot holds a character |
| tx_data | output | 8 | Character offered to the serial engine |
| tx_take | input | 1 | Serial engine accepts the offered character |
| baud_div | output | 16 | Baud divisor for the serial engine |

## Verification
The assertions assume that every bus access is a single-cycle strobe. They also assume that the serial engine pulses tx_take only while tx_valid is high. The stimulus drives each strobe for exactly one clock and never collides a receive strobe with a data read in the same cycle. That keeps the expected queue counts simple to derive, and the check of the overflow rule depends on this. Interrupt values are sampled one cycle after each state change, because the line is registered.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  typedef enum logic [2:0] {
    SEL_ID0   = 3'd0,
    SEL_ID1   = 3'd1,
    SEL_ID2   = 3'd2,
    SEL_ID3   = 3'd3,
    SEL_DATA  = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_BAUDL = 3'd6,
    SEL_BAUDH = 3'd7
  } reg_sel_e;

  localparam int B_FERR   = 0;
  localparam int B_OVF    = 1;
  localparam int B_RXIE   = 2;
  localparam int B_FULL   = 3;
  localparam int B_ROOM1  = 4;
  localparam int B_RXEMP  = 5;
  localparam int B_TXIE   = 6;
  localparam int B_TXEMP  = 7;
endpackage

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic [DW-1:0] din,
  input  logic          pop_req,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          room1,
  output logic          empty,
  output logic          drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign room1   = (cnt == CW'(DEPTH - 1));
  assign empty   = (cnt == '0);
  assign do_pop  = pop_req && !empty;
  assign do_push = push_req && (!full || do_pop);
  assign drop    = push_req && full && !do_pop;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_drop_keeps_full_R6: assert property (@(posedge clk) disable iff (rst)
    (push_req && full && !pop_req) |=> full);

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty && !push_req) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/urf_tx_hold.sv
module urf_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (valid) begin
      if (take) valid <= 1'b0;
    end else if (load_req) begin
      valid <= 1'b1;
      dout  <= din;
    end
  end

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && load_req) |=> $stable(dout));
endmodule

// File: rtl/urf_status_ctl.sv
module urf_status_ctl
  import uart_regfront_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stat,
  input  logic [7:0] wdata,
  input  logic       ferr_evt,
  input  logic       ovf_evt,
  input  logic       rx_empty,
  input  logic       tx_empty,
  output logic       rxie,
  output logic       txie,
  output logic       ferr,
  output logic       ovf,
  output logic       irq
);
  logic clr_ferr, clr_ovf, rx_cause, tx_cause;

  assign clr_ferr = wr_stat && !wdata[B_FERR];
  assign clr_ovf  = wr_stat && !wdata[B_OVF];
  assign rx_cause = rxie && (!rx_empty || ferr || ovf);
  assign tx_cause = txie && tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxie <= 1'b0;
      txie <= 1'b0;
      ferr <= 1'b0;
      ovf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wr_stat) begin
        rxie <= wdata[B_RXIE];
        txie <= wdata[B_TXIE];
      end
      ferr <= ferr_evt || (ferr && !clr_ferr);
      ovf  <= ovf_evt  || (ovf  && !clr_ovf);
      irq  <= rx_cause || tx_cause;
    end
  end

  assert_tx_cause_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (txie && tx_empty) |=> irq);

  assert_ovf_latches_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf);

  assert_ferr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ferr && !wr_stat) |=> ferr);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter int          RX_DEPTH = 4,
  parameter logic [31:0] ID_WORD = 32'h4B_52_55_01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_frame_err,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_take,
  output logic [15:0]       baud_div
);
  localparam int DW = 8;

  reg_sel_e sel;
  logic     hit, rd_en, wr_en;
  logic     rx_pop, tx_load, wr_stat;
  logic [DW-1:0] rx_head;
  logic     rx_full, rx_room1, rx_empty, rx_drop;
  logic     rxie, txie, ferr, ovf;
  logic [7:0] stat_byte, rd_mux;
  logic [7:0] baud_lo, baud_hi;

  assign sel     = reg_sel_e'(bus_addr[4:2]);
  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);
  assign rd_en   = hit && !bus_wr;
  assign wr_en   = hit && bus_wr;
  assign rx_pop  = rd_en && (sel == SEL_DATA);
  assign tx_load = wr_en && (sel == SEL_DATA);
  assign wr_stat = wr_en && (sel == SEL_STAT);

  urf_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .push_req(rx_valid), .din(rx_data),
    .pop_req(rx_pop), .dout(rx_head), .full(rx_full), .room1(rx_room1),
    .empty(rx_empty), .drop(rx_drop)
  );

  urf_tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .load_req(tx_load), .din(bus_wdata),
    .take(tx_take), .valid(tx_valid), .dout(tx_data)
  );

  urf_status_ctl u_stat (
    .clk(clk), .rst(rst), .wr_stat(wr_stat), .wdata(bus_wdata),
    .ferr_evt(rx_frame_err), .ovf_evt(rx_drop), .rx_empty(rx_empty),
    .tx_empty(!tx_valid), .rxie(rxie), .txie(txie), .ferr(ferr), .ovf(ovf),
    .irq(irq)
  );

  always_comb begin
    stat_byte          = '0;
    stat_byte[B_FERR]  = ferr;
    stat_byte[B_OVF]   = ovf;
    stat_byte[B_RXIE]  = rxie;
    stat_byte[B_FULL]  = rx_full;
    stat_byte[B_ROOM1] = rx_room1;
    stat_byte[B_RXEMP] = rx_empty;
    stat_byte[B_TXIE]  = txie;
    stat_byte[B_TXEMP] = !tx_valid;
  end

  always_comb begin
    case (sel)
      SEL_ID0:   rd_mux = ID_WORD[7:0];
      SEL_ID1:   rd_mux = ID_WORD[15:8];
      SEL_ID2:   rd_mux = ID_WORD[23:16];
      SEL_ID3:   rd_mux = ID_WORD[31:24];
      SEL_DATA:  rd_mux = rx_empty ? 8'h00 : rx_head;
      SEL_STAT:  rd_mux = stat_byte;
      SEL_BAUDL: rd_mux = baud_lo;
      default:   rd_mux = baud_hi;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      baud_lo   <= '0;
      baud_hi   <= '0;
    end else begin
      if (rd_en) bus_rdata <= rd_mux;
      if (wr_en && sel == SEL_BAUDL) baud_lo <= bus_wdata;
      if (wr_en && sel == SEL_BAUDH) baud_hi <= bus_wdata;
    end
  end

  assign baud_div = {baud_hi, baud_lo};

  assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> (bus_rdata == 8'h00));

  assert_full_flags_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_full, rx_room1, rx_empty}));
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  localparam logic [31:0] ID = 32'h4B_52_55_01;
  localparam logic [4:0] A_ID0 = 5'd0, A_ID1 = 5'd4, A_ID2 = 5'd8, A_ID3 = 5'd12;
  localparam logic [4:0] A_DATA = 5'd16, A_STAT = 5'd20, A_BL = 5'd24, A_BH = 5'd28;
  // {pushed byte, expected status after push}; rxie=0, tx empty
  localparam logic [15:0] VEC [5] = '{16'h11_80, 16'h22_80, 16'h33_90, 16'h44_88, 16'h55_8A};

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic irq, rx_valid = 0, rx_frame_err = 0, tx_valid, tx_take = 0;
  logic [7:0] rx_data = '0, tx_data;
  logic [15:0] baud_div;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  uart_regfront #(.ID_WORD(ID)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .baud_div(baud_div)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    rd(A_STAT, rv); chk("R1 status", rv, 8'hA0);
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0); chk("R1 baud", baud_div, 0);
    // R2 identification
    rd(A_ID0, rv); chk("R2 id0", rv, ID[7:0]);
    rd(A_ID1, rv); chk("R2 id1", rv, ID[15:8]);
    rd(A_ID2, rv); chk("R2 id2", rv, ID[23:16]);
    rd(A_ID3, rv); chk("R2 id3", rv, ID[31:24]);
    wr(A_ID0, 8'hFF); rd(A_ID0, rv); chk("R2 id0 write ignored", rv, ID[7:0]);
    // R4 R5 R6 table walk
    for (int i = 0; i < 5; i++) begin
      rx_push(VEC[i][15:8]);
      rd(A_STAT, rv); chk("R5 R6 level after push", rv, VEC[i][7:0]);
    end
    // R8: ones to error bits keep them, read-only bits ignore writes
    wr(A_STAT, 8'h3B); rd(A_STAT, rv); chk("R8 write ones keep", rv, 8'h8A);
    for (int i = 0; i < 4; i++) begin
      rd(A_DATA, rv); chk("R4 order", rv, VEC[i][15:8]);
    end
    rd(A_STAT, rv); chk("R6 dropped byte, empty", rv, 8'hA2);
    // R11 empty read
    rd(A_DATA, rv); chk("R11 empty data", rv, 8'h00);
    rd(A_STAT, rv); chk("R11 status unchanged", rv, 8'hA2);
    // R10 error-only receive interrupt
    wr(A_STAT, 8'h06); @(negedge clk); chk("R10 irq on ovf only", irq, 1);
    wr(A_STAT, 8'h04); @(negedge clk); chk("R10 irq cleared", irq, 0);
    rd(A_STAT, rv); chk("R8 ovf cleared", rv, 8'hA4);
    // R7 frame error sticky
    rx_frame_err = 1; @(negedge clk); rx_frame_err = 0; @(negedge clk);
    rd(A_STAT, rv); chk("R7 frame err set", rv, 8'hA5);
    rd(A_STAT, rv); chk("R7 frame err sticky", rv, 8'hA5);
    chk("R10 irq on frame err", irq, 1);
    wr(A_STAT, 8'h04); @(negedge clk); chk("R7 cleared irq", irq, 0);
    rx_push(8'h77); @(negedge clk); chk("R10 irq data", irq, 1);
    rd(A_DATA, rv); chk("R4 single", rv, 8'h77);
    @(negedge clk); chk("R10 irq after pop", irq, 0);
    // R9 transmit slot
    wr(A_STAT, 8'h00);
    wr(A_DATA, 8'h5A);
    chk("R9 tx_valid", tx_valid, 1); chk("R9 tx_data", tx_data, 8'h5A);
    rd(A_STAT, rv); chk("R9 txempty clear", rv, 8'h20);
    wr(A_DATA, 8'h33); chk("R9 busy write ignored", tx_data, 8'h5A);
    wr(A_STAT, 8'h40); @(negedge clk); chk("R10 no tx irq busy", irq, 0);
    tx_take = 1; @(negedge clk); tx_take = 0;
    chk("R9 taken", tx_valid, 0);
    @(negedge clk); chk("R10 tx irq", irq, 1);
    rd(A_STAT, rv); chk("R9 txempty back", rv, 8'hE0);
    wr(A_STAT, 8'h00); @(negedge clk); chk("R10 tx irq off", irq, 0);
    // R3 baud
    wr(A_BL, 8'h34); wr(A_BH, 8'h12);
    chk("R3 baud_div", baud_div, 16'h1234);
    rd(A_BL, rv); chk("R3 low readback", rv, 8'h34);
    rd(A_BH, rv); chk("R3 high readback", rv, 8'h12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule